// File: doc/BRIEF.md
# Dual-Layer Monochrome Display Compositor

The compositor scans out a monochrome raster built from two 1-bit-per-pixel image layers held in video memory. The lower layer carries the screen content ("paper") and the upper layer carries pen strokes ("acetate"). Each layer owns three frame buffers. A small select register per layer names the one buffer that is shown. The displayed pixel is the logical OR of the two layers at the same screen position. The buffers that are not selected are never read, so other agents may keep cached glyphs or icons in them.

A free-running raster counter walks the active area and the blanking intervals. At every 16-pixel boundary inside the active area, each layer issues one word read on its own synchronous memory port. The returned word is shifted out MSB first. The first bit comes straight from the read data, so the pixel stream has no gaps. The output carries the composited pixel and one-cycle line and frame strobes, all aligned to the same cycle. A select write is held as pending and moves into the active select only when the raster wraps to a new frame.

Top module: `vid_compositor`

## Requirements
- R1: After reset, pix_o, line_o and frame_o are 0 and both active selects are buffer 0. The first frame after reset displays paper buffer 0 merged with acetate buffer 0.
- R2: Pixel x of active line y is the OR of the two layer bits. Each layer bit is bit (15 - x mod 16) of word (y*WPL + x/16) in that layer's active buffer, with WPL = H_PIX/16. A layer whose buffer is all zero therefore leaves the other layer shown unchanged.
- R3: Paper buffer k starts at word address k*BUF_WORDS and acetate buffer k starts at (3+k)*BUF_WORDS, with BUF_WORDS = WPL*V_LINES. Every read a layer issues during a frame falls inside that layer's active buffer for the frame.
- R4: Each layer issues exactly WPL*V_LINES one-cycle read requests per frame, one at each 16-pixel boundary of the active area. The memory returns the data one cycle after the request.
- R5: A select write (psel_we_i or asel_we_i high for one cycle) takes effect at the first frame that starts after the clock edge that samples it. A write sampled at the frame-wrap edge itself takes effect one frame later. The frame in which the write occurs keeps its old buffers to the end.
- R6: A select write with value 3 is ignored: the pending and active selects of that layer keep their previous value.
- R7: pix_o is 0 at every raster position outside the H_PIX x V_LINES active area.
- R8: line_o is high for exactly one cycle, in the cycle that carries the first pixel of each of the V_LINES+V_BLANK raster lines. frame_o is high only in the cycle that carries pixel (0,0). Pixel (x,y) appears y*(H_PIX+H_BLANK)+x cycles after frame_o. The first frame_o comes two cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 2 | Paper buffer select value (0..2, 3 reserved) |
| psel_we_i | input | 1 | Paper select write strobe |
| asel_i | input | 2 | Acetate buffer select value (0..2, 3 reserved) |
| asel_we_i | input | 1 | Acetate select write strobe |
| pmem_req_o | output | 1 | Paper layer read request |
| pmem_addr_o | output | AW | Paper layer word address |
| pmem_rdata_i | input | 16 | Paper layer read data, valid one cycle after request |
| amem_req_o | output | 1 | Acetate layer read request |
| amem_addr_o | output | AW | Acetate layer word address |
| amem_rdata_i | input | 16 | Acetate layer read data, valid one cycle after request |
| pix_o | output | 1 | Composited pixel |
| line_o | output | 1 | Line start strobe |
| frame_o | output | 1 | Frame start strobe |

## Verification
The assertions assume that H_PIX is a multiple of 16, and that each memory port returns the addressed word exactly one cycle after its request with no stall. The bench's memory model has this latency and never withholds data. Select writes are one-cycle pulses driven between clock edges. They are placed at ordinary mid-frame positions and also exactly on the frame-wrap edge and the edge before it, which exercises the pending/active hand-over at both sides of the boundary. Buffer contents are chosen so that some buffers are entirely zero, so that each layer can be seen both alone and merged.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int WORD_W = 16;
  localparam int BUFS_PER_LAYER = 3;
  localparam int NUM_LAYERS = 2;
  typedef logic [1:0] buf_sel_t;
  localparam buf_sel_t SEL_RESERVED = 2'd3;
endpackage

// File: rtl/vc_raster.sv
module vc_raster #(
  parameter int H_PIX   = 32,
  parameter int H_BLANK = 8,
  parameter int V_LINES = 4,
  parameter int V_BLANK = 2,
  parameter int HW      = 6,
  parameter int VW      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          active_o,
  output logic          line_start_o,
  output logic          frame_start_o,
  output logic          wrap_o
);
  localparam int HT = H_PIX + H_BLANK;
  localparam int VT = V_LINES + V_BLANK;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_last, v_last;

  assign h_last = (h_q == HW'(HT - 1));
  assign v_last = (v_q == VW'(VT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_last) begin
      h_q <= '0;
      v_q <= v_last ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o           = h_q;
  assign v_o           = v_q;
  assign active_o      = (h_q < HW'(H_PIX)) && (v_q < VW'(V_LINES));
  assign line_start_o  = (h_q == '0);
  assign frame_start_o = (h_q == '0) && (v_q == '0);
  assign wrap_o        = h_last && v_last;

  // R8: a wrap is always followed by the first position of a frame
  p_wrap_to_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> frame_start_o);
  p_line_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o);
endmodule

// File: rtl/vc_sel_reg.sv
module vc_sel_reg
  import vc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  buf_sel_t val_i,
  input  logic     wrap_i,
  output buf_sel_t act_o
);
  buf_sel_t pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i && val_i != SEL_RESERVED) pend_q <= val_i;
      if (wrap_i) act_q <= pend_q;
    end
  end

  assign act_o = act_q;

  p_hold_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_o));
  p_reserved_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && val_i == SEL_RESERVED) |=> $stable(pend_q));
  p_act_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> act_o != SEL_RESERVED);
endmodule

// File: rtl/vc_layer_fetch.sv
module vc_layer_fetch
  import vc_pkg::*;
#(
  parameter int LAYER     = 0,
  parameter int WPL       = 2,
  parameter int BUF_WORDS = 8,
  parameter int AW        = 6,
  parameter int VW        = 3,
  parameter int WIW       = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [VW-1:0]     line_i,
  input  logic [WIW-1:0]    word_i,
  input  buf_sel_t          sel_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              req_o,
  output logic [AW-1:0]     addr_o,
  output logic              bit_o
);
  localparam int REGION_LO = LAYER * BUFS_PER_LAYER * BUF_WORDS;
  localparam int REGION_HI = REGION_LO + BUFS_PER_LAYER * BUF_WORDS;

  logic [WORD_W-1:0] sh_q;
  int                base, offs;

  always_comb begin
    base   = (LAYER * BUFS_PER_LAYER + int'(sel_i)) * BUF_WORDS;
    offs   = int'(line_i) * WPL + int'(word_i);
    addr_o = AW'(base + offs);
  end

  assign req_o = fetch_i;

  // first bit bypasses the shifter so the stream stays gapless
  assign bit_o = load_i ? rdata_i[WORD_W-1] : sh_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= {rdata_i[WORD_W-2:0], 1'b0};
    else             sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  p_addr_in_region_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (int'(addr_o) >= REGION_LO) && (int'(addr_o) < REGION_HI));
  p_single_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

// File: rtl/vid_compositor.sv
module vid_compositor
  import vc_pkg::*;
#(
  parameter int H_PIX   = 32,
  parameter int H_BLANK = 8,
  parameter int V_LINES = 4,
  parameter int V_BLANK = 2,
  localparam int WPL       = H_PIX / WORD_W,
  localparam int BUF_WORDS = WPL * V_LINES,
  localparam int AW        = $clog2(NUM_LAYERS * BUFS_PER_LAYER * BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        psel_i,
  input  logic              psel_we_i,
  input  logic [1:0]        asel_i,
  input  logic              asel_we_i,
  output logic              pmem_req_o,
  output logic [AW-1:0]     pmem_addr_o,
  input  logic [WORD_W-1:0] pmem_rdata_i,
  output logic              amem_req_o,
  output logic [AW-1:0]     amem_addr_o,
  input  logic [WORD_W-1:0] amem_rdata_i,
  output logic              pix_o,
  output logic              line_o,
  output logic              frame_o
);
  localparam int HT  = H_PIX + H_BLANK;
  localparam int VT  = V_LINES + V_BLANK;
  localparam int HW  = $clog2(HT);
  localparam int VW  = (VT > 1) ? $clog2(VT) : 1;
  localparam int WIW = (WPL > 1) ? $clog2(WPL) : 1;

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          active, line_start, frame_start, wrap, fetch;
  logic [WIW-1:0] word_idx;

  vc_raster #(
    .H_PIX(H_PIX), .H_BLANK(H_BLANK), .V_LINES(V_LINES), .V_BLANK(V_BLANK),
    .HW(HW), .VW(VW)
  ) u_raster (
    .clk_i, .rst_ni,
    .h_o(h_cnt), .v_o(v_cnt), .active_o(active),
    .line_start_o(line_start), .frame_start_o(frame_start), .wrap_o(wrap)
  );

  assign fetch    = active && (h_cnt[3:0] == 4'd0);
  assign word_idx = WIW'(h_cnt >> 4);

  buf_sel_t          sel_val [NUM_LAYERS];
  buf_sel_t          act_sel [NUM_LAYERS];
  logic [WORD_W-1:0] rdata   [NUM_LAYERS];
  logic [AW-1:0]     addr    [NUM_LAYERS];
  logic [NUM_LAYERS-1:0] sel_we, req, lbit;
  logic act_d1, line_d1, frame_d1, load_d1;

  assign sel_val[0] = psel_i;
  assign sel_val[1] = asel_i;
  assign sel_we     = {asel_we_i, psel_we_i};
  assign rdata[0]   = pmem_rdata_i;
  assign rdata[1]   = amem_rdata_i;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    vc_sel_reg u_sel (
      .clk_i, .rst_ni,
      .wr_i(sel_we[l]), .val_i(sel_val[l]), .wrap_i(wrap), .act_o(act_sel[l])
    );
    vc_layer_fetch #(
      .LAYER(l), .WPL(WPL), .BUF_WORDS(BUF_WORDS), .AW(AW), .VW(VW), .WIW(WIW)
    ) u_fetch (
      .clk_i, .rst_ni,
      .fetch_i(fetch), .line_i(v_cnt), .word_i(word_idx), .sel_i(act_sel[l]),
      .load_i(load_d1), .rdata_i(rdata[l]),
      .req_o(req[l]), .addr_o(addr[l]), .bit_o(lbit[l])
    );
  end

  assign pmem_req_o  = req[0];
  assign pmem_addr_o = addr[0];
  assign amem_req_o  = req[1];
  assign amem_addr_o = addr[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d1   <= 1'b0;
      line_d1  <= 1'b0;
      frame_d1 <= 1'b0;
      load_d1  <= 1'b0;
      pix_o    <= 1'b0;
      line_o   <= 1'b0;
      frame_o  <= 1'b0;
    end else begin
      act_d1   <= active;
      line_d1  <= line_start;
      frame_d1 <= frame_start;
      load_d1  <= fetch;
      pix_o    <= act_d1 & (|lbit);
      line_o   <= line_d1;
      frame_o  <= frame_d1;
    end
  end

  p_blank_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_d1 |=> !pix_o);
  p_line_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |=> !line_o);
  p_frame_on_line_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> line_o);
  p_layers_lockstep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmem_req_o == amem_req_o);
endmodule

// File: tb/vid_compositor_test.sv
module vid_compositor_test;
  localparam int H_PIX = 32, H_BLANK = 8, V_LINES = 4, V_BLANK = 2;
  localparam int HT = H_PIX + H_BLANK, VT = V_LINES + V_BLANK, NPOS = HT * VT;
  localparam int WPL = H_PIX / 16, BW = WPL * V_LINES, AW = 6, MEMW = 6 * BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] psel = '0, asel = '0;
  logic psel_we = 1'b0, asel_we = 1'b0;
  logic preq, areq, pix, line_s, frame_s;
  logic [AW-1:0] paddr, aaddr;
  logic [15:0] prdata, ardata;
  logic [15:0] mem [MEMW];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vid_compositor #(.H_PIX(H_PIX), .H_BLANK(H_BLANK), .V_LINES(V_LINES), .V_BLANK(V_BLANK)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .psel_i(psel), .psel_we_i(psel_we), .asel_i(asel), .asel_we_i(asel_we),
    .pmem_req_o(preq), .pmem_addr_o(paddr), .pmem_rdata_i(prdata),
    .amem_req_o(areq), .amem_addr_o(aaddr), .amem_rdata_i(ardata),
    .pix_o(pix), .line_o(line_s), .frame_o(frame_s)
  );

  function automatic logic [15:0] pat(int b, int i);
    if (b == 2 || b == 4) return 16'h0000;  // paper buf 2 and acetate buf 1 blank
    return 16'((b * 4951) ^ (i * 12041) ^ 42435);
  endfunction

  function automatic bit exp_pix(int ps, int as, int x, int y);
    logic [15:0] wp, wa;
    int idx;
    if (x >= H_PIX || y >= V_LINES) return 1'b0;
    idx = y * WPL + x / 16;
    wp = pat(ps, idx);
    wa = pat(3 + as, idx);
    return wp[15 - x % 16] | wa[15 - x % 16];
  endfunction

  // synchronous RAM, one-cycle read latency
  always @(posedge clk) begin
    if (preq) prdata <= mem[paddr];
    if (areq) ardata <= mem[aaddr];
  end

  // request monitor, delayed by 2 cycles to align with the pixel output
  logic pq1 = 0, pq2 = 0, aq1 = 0, aq2 = 0;
  int pa1, pa2, aa1, aa2;
  int p_cnt, p_min, p_max, a_cnt, a_min, a_max;
  always @(negedge clk) begin
    logic pr, ar;
    int pad, aad;
    pr = pq2; pad = pa2; ar = aq2; aad = aa2;
    pq2 = pq1; pa2 = pa1; aq2 = aq1; aa2 = aa1;
    pq1 = preq; pa1 = int'(paddr); aq1 = areq; aa1 = int'(aaddr);
    if (frame_s) begin
      p_cnt = 0; p_min = 9999; p_max = -1;
      a_cnt = 0; a_min = 9999; a_max = -1;
    end
    if (pr) begin
      p_cnt++; if (pad < p_min) p_min = pad; if (pad > p_max) p_max = pad;
    end
    if (ar) begin
      a_cnt++; if (aad < a_min) a_min = aad; if (aad > a_max) a_max = aad;
    end
  end

  task automatic check(bit ok, string msg, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // capture one frame starting at frame_o, optionally writing selects at position wr_pos
  task automatic capture(int ps, int as, string tag, bit do_wr = 0, int wr_pos = 0,
                         logic [1:0] wp = 0, logic [1:0] wa = 0);
    int pix_bad = 0, str_bad = 0, first_a = 0, first_e = 0, fx = 0, fy = 0;
    while (!frame_s) @(negedge clk);
    for (int p = 0; p < NPOS; p++) begin
      int x, y;
      bit e;
      x = p % HT; y = p / HT;
      psel_we = 1'b0; asel_we = 1'b0;
      e = exp_pix(ps, as, x, y);
      if (pix !== e) begin
        if (pix_bad == 0) begin first_a = int'(pix); first_e = int'(e); fx = x; fy = y; end
        pix_bad++;
      end
      if (line_s !== (x == 0) || frame_s !== (p == 0)) str_bad++;
      if (do_wr && p == wr_pos) begin
        psel = wp; asel = wa; psel_we = 1'b1; asel_we = 1'b1;
      end
      if (p == NPOS - 1) begin
        #1;
        check(p_cnt == WPL * V_LINES && a_cnt == WPL * V_LINES,
              $sformatf("R4 %s request count (paper/acetate %0d/%0d)", tag, p_cnt, a_cnt),
              p_cnt + a_cnt, 2 * WPL * V_LINES);
        check(p_min >= ps * BW && p_max < (ps + 1) * BW,
              $sformatf("R3 %s paper addr range [%0d,%0d]", tag, p_min, p_max), p_min, ps * BW);
        check(a_min >= (3 + as) * BW && a_max < (4 + as) * BW,
              $sformatf("R3 %s acetate addr range [%0d,%0d]", tag, a_min, a_max), a_min, (3 + as) * BW);
      end else begin
        @(negedge clk);
      end
    end
    check(pix_bad == 0, $sformatf("R2 R7 %s pixel at x=%0d y=%0d", tag, fx, fy), first_a, first_e);
    check(str_bad == 0, $sformatf("R8 %s strobe mismatches", tag), str_bad, 0);
    @(negedge clk);
    psel_we = 1'b0; asel_we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pix === 1'b0 && line_s === 1'b0 && frame_s === 1'b0, "R1 outputs during reset",
          int'({pix, line_s, frame_s}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_s === 1'b0, "R8 frame_o one cycle after reset release", int'(frame_s), 0);
    @(negedge clk);
    check(frame_s === 1'b1, "R8 frame_o two cycles after reset release", int'(frame_s), 1);
  endtask

  task automatic t_default();
    capture(0, 0, "R1 default buffers");
  endtask

  task automatic t_switch_mid_frame();
    capture(0, 0, "R5 old buffers kept in write frame", 1, 45, 2'd1, 2'd2);
    capture(1, 2, "R5 new buffers next frame");
  endtask

  task automatic t_single_layer();
    capture(1, 2, "R2 before switch", 1, 60, 2'd2, 2'd0);
    capture(2, 0, "R2 acetate alone");
    capture(2, 0, "R2 before switch", 1, 130, 2'd1, 2'd1);
    capture(1, 1, "R2 paper alone");
  endtask

  task automatic t_reserved();
    capture(1, 1, "R6 write p=3 a=0", 1, 100, 2'd3, 2'd0);
    capture(1, 0, "R6 paper unchanged by 3");
    capture(1, 0, "R6 write p=0 a=3", 1, 20, 2'd0, 2'd3);
    capture(0, 0, "R6 acetate unchanged by 3");
    capture(0, 0, "R6 still unchanged");
  endtask

  task automatic t_edge_write();
    capture(0, 0, "R5 write on wrap edge", 1, NPOS - 3, 2'd2, 2'd2);
    capture(0, 0, "R5 wrap-edge write deferred");
    capture(2, 2, "R5 wrap-edge write applied", 1, NPOS - 4, 2'd0, 2'd1);
    capture(0, 1, "R5 pre-wrap write applied");
  endtask

  initial begin
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < BW; i++) mem[b * BW + i] = pat(b, i);
    t_reset();
    t_default();
    t_switch_mid_frame();
    t_single_layer();
    t_reserved();
    t_edge_write();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule